// File: doc/BRIEF.md
# Control-Line Arithmetic and Logic Unit

This block is an 8-bit arithmetic and logic unit. Its function is not chosen by one wide multiplexer keyed on the opcode. A small decoder turns each 5-bit opcode into a set of independent datapath controls: operand inversion, operand-B masking, a constant carry-in, a carry-in taken from the carry flag, carry suppression, an OR path, output inversion and an all-ones override. The datapath combines these controls over a single ripple adder and a single OR gate row. This covers addition, subtraction, add-with-carry, increment, decrement, XOR, AND and OR.

A request is one cycle with `in_valid` high, carrying an opcode and two operands. The answer leaves a three-stage pipeline exactly three clock edges later, together with `out_valid`. The carry, inverted-carry and zero flags are registered beside the result. Only the eight arithmetic and logic opcodes change the flags. A new request may be presented in every cycle.

Top module: `alu_ctl8`

## Requirements
- R1: `out_valid` is high in the cycle after the third rising edge that followed a cycle with `in_valid` high. It is never high otherwise, and `result` is presented in that same cycle.
- R2: Opcode 00011 gives A+B modulo 256, and carry becomes bit 8 of the 9-bit sum.
- R3: Opcode 00100 gives A+~B+1, which is A−B modulo 256. Carry becomes 1 when A ≥ B (no borrow) and 0 otherwise.
- R4: Opcode 10001 gives A+B+c, where c is the carry flag held by the block. Carry becomes bit 8 of that sum.
- R5: Opcode 10010 gives A+1 and opcode 10011 gives A+255 (A−1). B is ignored, and carry becomes bit 8 of the 9-bit sum.
- R6: Opcode 00101 gives A XOR B, 00111 gives A AND B and 01000 gives A OR B. Each of the three clears carry.
- R7: Opcode 11010 gives a result of 0xFF and leaves carry, inverted carry and zero unchanged.
- R8: Any opcode not named in R2–R7 gives a result of 0x00 and leaves all flags unchanged.
- R9: After an R2–R6 opcode, zero is 1 exactly when the result is 0x00. The inverted-carry output is always the complement of carry.
- R10: While reset is asserted and after its release, `out_valid`=0, `result`=0x00, carry=0, zero=0 and inverted carry=1 until the first result arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe, one operation per high cycle |
| opcode | input | 5 | Operation code |
| op_a | input | 8 | Operand A |
| op_b | input | 8 | Operand B |
| out_valid | output | 1 | Result strobe, three edges after the request |
| result | output | 8 | Operation result |
| carry | output | 1 | Carry flag |
| no_carry | output | 1 | Inverted carry flag |
| zero | output | 1 | Zero flag |

## Verification
The arithmetic opcodes are tried with operand pairs that wrap through 0xFF and pairs that do not, so a lost carry-out, a carry-in stuck at the wrong polarity or a swapped inversion line shows up. Subtraction is run with A above, below and equal to B, which separates borrow from no-borrow and exercises zero. The logic opcodes use complementary nibble patterns, so an AND built without the output inversion reads differently from OR. Flood, an unused opcode and add-with-carry after both carry states confirm that the flags are held or consumed as specified. The requests are issued back to back and with gaps, which shows the latency does not depend on the issue rate.

// File: rtl/alu_ctl8_pkg.sv
package alu_ctl8_pkg;

    localparam int OPW = 5;

    localparam logic [OPW-1:0] OPC_ADD   = 5'b00011;
    localparam logic [OPW-1:0] OPC_SUB   = 5'b00100;
    localparam logic [OPW-1:0] OPC_XOR   = 5'b00101;
    localparam logic [OPW-1:0] OPC_AND   = 5'b00111;
    localparam logic [OPW-1:0] OPC_IOR   = 5'b01000;
    localparam logic [OPW-1:0] OPC_ADC   = 5'b10001;
    localparam logic [OPW-1:0] OPC_INC   = 5'b10010;
    localparam logic [OPW-1:0] OPC_DEC   = 5'b10011;
    localparam logic [OPW-1:0] OPC_FLOOD = 5'b11010;

    typedef struct packed {
        logic inv_a;      // complement operand A
        logic inv_b;      // complement operand B (after masking)
        logic zero_b;     // mask operand B to zero
        logic cin_one;    // constant carry-in of one
        logic cin_flag;   // carry-in from the held carry flag
        logic carry_kill; // suppress carry chain into sum bits
        logic or_mode;    // take the OR row instead of the sum
        logic inv_out;    // complement the selected row
        logic flood;      // force all ones
        logic upd_flags;  // arithmetic/logic op: write flags
        logic logic_op;   // carry flag is cleared
    } ctrl_t;

    function automatic logic is_alu_op(input logic [OPW-1:0] op);
        return (op == OPC_ADD) || (op == OPC_SUB) || (op == OPC_XOR) ||
               (op == OPC_AND) || (op == OPC_IOR) || (op == OPC_ADC) ||
               (op == OPC_INC) || (op == OPC_DEC);
    endfunction

endpackage

// File: rtl/alu_ctl8_dec.sv
module alu_ctl8_dec
    import alu_ctl8_pkg::*;
(
    input  logic [OPW-1:0] opcode,
    output ctrl_t          ctrl
);

    always_comb begin
        ctrl = '0;
        unique case (opcode)
            OPC_ADD: begin
                ctrl.upd_flags = 1'b1;
            end
            OPC_SUB: begin
                ctrl.inv_b     = 1'b1;
                ctrl.cin_one   = 1'b1;
                ctrl.upd_flags = 1'b1;
            end
            OPC_ADC: begin
                ctrl.cin_flag  = 1'b1;
                ctrl.upd_flags = 1'b1;
            end
            OPC_INC: begin
                ctrl.zero_b    = 1'b1;
                ctrl.cin_one   = 1'b1;
                ctrl.upd_flags = 1'b1;
            end
            OPC_DEC: begin
                ctrl.zero_b    = 1'b1;
                ctrl.inv_b     = 1'b1;
                ctrl.upd_flags = 1'b1;
            end
            OPC_XOR: begin
                ctrl.carry_kill = 1'b1;
                ctrl.logic_op   = 1'b1;
                ctrl.upd_flags  = 1'b1;
            end
            OPC_IOR: begin
                ctrl.or_mode   = 1'b1;
                ctrl.logic_op  = 1'b1;
                ctrl.upd_flags = 1'b1;
            end
            OPC_AND: begin
                ctrl.inv_a     = 1'b1;
                ctrl.inv_b     = 1'b1;
                ctrl.or_mode   = 1'b1;
                ctrl.inv_out   = 1'b1;
                ctrl.logic_op  = 1'b1;
                ctrl.upd_flags = 1'b1;
            end
            OPC_FLOOD: begin
                ctrl.flood = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/alu_ctl8_core.sv
module alu_ctl8_core
    import alu_ctl8_pkg::*;
#(
    parameter int W = 8
) (
    input  ctrl_t          ctrl,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cflag,
    output logic [W-1:0]   res,
    output logic           cout
);

    logic [W-1:0] a_x;
    logic [W-1:0] b_m;
    logic [W-1:0] b_x;
    logic [W:0]   chain;
    logic [W-1:0] sum;
    logic [W-1:0] or_row;
    logic [W-1:0] pre;
    logic [W-1:0] post;

    assign a_x      = ctrl.inv_a ? ~a : a;
    assign b_m      = ctrl.zero_b ? '0 : b;
    assign b_x      = ctrl.inv_b ? ~b_m : b_m;
    assign chain[0] = ctrl.cin_one | (ctrl.cin_flag & cflag);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]      = a_x[i] ^ b_x[i] ^ (chain[i] & ~ctrl.carry_kill);
        assign chain[i+1]  = (a_x[i] & b_x[i]) | (chain[i] & (a_x[i] ^ b_x[i]));
        assign or_row[i]   = a_x[i] | b_x[i];
    end

    assign pre  = ctrl.or_mode ? or_row : sum;
    assign post = ctrl.inv_out ? ~pre : pre;

    always_comb begin
        if (ctrl.flood) begin
            res = '1;
        end else if (ctrl.upd_flags) begin
            res = post;
        end else begin
            res = '0;
        end
        cout = ctrl.logic_op ? 1'b0 : chain[W];
    end

endmodule

// File: rtl/alu_ctl8.sv
module alu_ctl8
    import alu_ctl8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [4:0]     opcode,
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic           out_valid,
    output logic [W-1:0]   result,
    output logic           carry,
    output logic           no_carry,
    output logic           zero
);

    typedef struct packed {
        logic         s1_vld;
        ctrl_t        s1_ctrl;
        logic [W-1:0] s1_a;
        logic [W-1:0] s1_b;
        logic         s2_vld;
        logic         s2_upd;
        logic [W-1:0] s2_res;
        logic         s2_cout;
        logic         o_vld;
        logic [W-1:0] o_res;
        logic         f_c;
        logic         f_nc;
        logic         f_z;
    } state_t;

    localparam state_t RST_STATE = '{
        s1_vld: 1'b0, s1_ctrl: '0, s1_a: '0, s1_b: '0,
        s2_vld: 1'b0, s2_upd: 1'b0, s2_res: '0, s2_cout: 1'b0,
        o_vld: 1'b0, o_res: '0, f_c: 1'b0, f_nc: 1'b1, f_z: 1'b0
    };

    state_t       st_d;
    state_t       st_q;
    ctrl_t        dec_ctrl;
    logic [W-1:0] core_res;
    logic         core_cout;

    alu_ctl8_dec u_dec (
        .opcode (opcode),
        .ctrl   (dec_ctrl)
    );

    alu_ctl8_core #(.W(W)) u_core (
        .ctrl  (st_q.s1_ctrl),
        .a     (st_q.s1_a),
        .b     (st_q.s1_b),
        .cflag (st_q.f_c),
        .res   (core_res),
        .cout  (core_cout)
    );

    always_comb begin
        st_d = st_q;

        // stage 1: capture decoded controls and operands
        st_d.s1_vld = in_valid;
        if (in_valid) begin
            st_d.s1_ctrl = dec_ctrl;
            st_d.s1_a    = op_a;
            st_d.s1_b    = op_b;
        end else begin
            st_d.s1_ctrl = '0;
        end

        // stage 2: register datapath output
        st_d.s2_vld  = st_q.s1_vld;
        st_d.s2_upd  = st_q.s1_vld & st_q.s1_ctrl.upd_flags;
        st_d.s2_res  = core_res;
        st_d.s2_cout = core_cout;

        // stage 3: present result, update flags
        st_d.o_vld = st_q.s2_vld;
        if (st_q.s2_vld) begin
            st_d.o_res = st_q.s2_res;
        end
        if (st_q.s2_upd) begin
            st_d.f_c  = st_q.s2_cout;
            st_d.f_nc = ~st_q.s2_cout;
            st_d.f_z  = (st_q.s2_res == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.o_vld;
    assign result    = st_q.o_res;
    assign carry     = st_q.f_c;
    assign no_carry  = st_q.f_nc;
    assign zero      = st_q.f_z;

endmodule

// File: rtl/alu_ctl8_chk.sv
module alu_ctl8_chk
    import alu_ctl8_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [4:0]   opcode,
    input logic         out_valid,
    input logic [W-1:0] result,
    input logic         carry,
    input logic         no_carry,
    input logic         zero
);

    logic [1:0] age_q;
    logic       warm;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    assign warm = (age_q == 2'd3);

    // R1: strobe follows request by three edges
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 3)));

    // R7: flood gives all ones and holds flags
    a_r7_flood: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && $past(opcode, 3) == OPC_FLOOD)
        |-> (result == '1 && $stable({carry, no_carry, zero})));

    // R8: unlisted opcodes give zero and hold flags
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && !is_alu_op($past(opcode, 3)) && $past(opcode, 3) != OPC_FLOOD)
        |-> (result == '0 && $stable({carry, no_carry, zero})));

    // R9: zero flag tracks result for arithmetic/logic ops
    a_r9_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && is_alu_op($past(opcode, 3)))
        |-> (zero == (result == '0)));

    // R9: inverted carry is the complement of carry
    a_r9_ncarry: assert property (@(posedge clk) disable iff (!rst_n)
        no_carry != carry);

    // R6: logic ops clear carry
    a_r6_logic_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && ($past(opcode, 3) == OPC_XOR ||
                               $past(opcode, 3) == OPC_AND ||
                               $past(opcode, 3) == OPC_IOR))
        |-> !carry);

endmodule

bind alu_ctl8 alu_ctl8_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .out_valid (out_valid),
    .result    (result),
    .carry     (carry),
    .no_carry  (no_carry),
    .zero      (zero)
);

// File: tb/sim_alu_ctl8.sv
module sim_alu_ctl8;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 5000;

    typedef struct {
        logic [7:0] res;
        logic       c;
        logic       z;
        int         cyc;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [4:0] opcode = 5'd0;
    logic [7:0] op_a = 8'd0;
    logic [7:0] op_b = 8'd0;
    logic       out_valid;
    logic [7:0] result;
    logic       carry;
    logic       no_carry;
    logic       zero;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    logic mc = 1'b0;
    logic mz = 1'b0;
    logic done = 1'b0;
    exp_t sb[$];

    alu_ctl8 u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .opcode    (opcode),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_valid (out_valid),
        .result    (result),
        .carry     (carry),
        .no_carry  (no_carry),
        .zero      (zero)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic issue(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b);
        exp_t    e;
        logic [8:0] s;
        logic    upd;
        @(negedge clk);
        in_valid = 1'b1;
        opcode   = op;
        op_a     = a;
        op_b     = b;
        upd      = 1'b1;
        case (op)
            5'b00011: begin s = {1'b0, a} + {1'b0, b};               e.tag = "R2"; end
            5'b00100: begin s = {1'b0, a} + {1'b0, ~b} + 9'd1;       e.tag = "R3"; end
            5'b10001: begin s = {1'b0, a} + {1'b0, b} + {8'd0, mc};  e.tag = "R4"; end
            5'b10010: begin s = {1'b0, a} + 9'd1;                    e.tag = "R5"; end
            5'b10011: begin s = {1'b0, a} + 9'd255;                  e.tag = "R5"; end
            5'b00101: begin s = {1'b0, a ^ b};                       e.tag = "R6"; end
            5'b00111: begin s = {1'b0, a & b};                       e.tag = "R6"; end
            5'b01000: begin s = {1'b0, a | b};                       e.tag = "R6"; end
            5'b11010: begin s = 9'h0FF; upd = 1'b0;                  e.tag = "R7"; end
            default:  begin s = 9'h000; upd = 1'b0;                  e.tag = "R8"; end
        endcase
        if (upd) begin
            mc = s[8];
            mz = (s[7:0] == 8'd0);
        end
        e.res = s[7:0];
        e.c   = mc;
        e.z   = mz;
        e.cyc = cyc;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opcode   = $urandom_range(0, 31);
            op_a     = $urandom_range(0, 255);
            op_b     = $urandom_range(0, 255);
        end
    endtask

    // monitor: pops expected items as results arrive
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R1 stray out_valid at cycle %0d: actual 1 expected 0", cyc);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (cyc - e.cyc != 3) begin
                    errors++;
                    $display("FAIL R1 latency: actual %0d expected 3", cyc - e.cyc);
                end
                if (result !== e.res || carry !== e.c || zero !== e.z || no_carry !== ~e.c) begin
                    errors++;
                    $display("FAIL %s/R9 res/c/nc/z: actual %h/%b/%b/%b expected %h/%b/%b/%b",
                             e.tag, result, carry, no_carry, zero, e.res, e.c, ~e.c, e.z);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        checks++;
        if (out_valid !== 1'b0 || result !== 8'h00 || carry !== 1'b0 || zero !== 1'b0 || no_carry !== 1'b1) begin
            errors++;
            $display("FAIL R10 in reset: actual v%b r%h c%b nc%b z%b expected v0 r00 c0 nc1 z0",
                     out_valid, result, carry, no_carry, zero);
        end
        rst_n = 1'b1;
        idle(2);
        checks++;
        if (out_valid !== 1'b0 || result !== 8'h00 || carry !== 1'b0 || zero !== 1'b0 || no_carry !== 1'b1) begin
            errors++;
            $display("FAIL R10 after release: actual v%b r%h c%b nc%b z%b expected v0 r00 c0 nc1 z0",
                     out_valid, result, carry, no_carry, zero);
        end

        // back-to-back stream
        issue(5'b00011, 8'h12, 8'h34);  // R2 no wrap
        issue(5'b00011, 8'hFF, 8'h01);  // R2 wrap, R9 zero
        issue(5'b00100, 8'h50, 8'h20);  // R3 A>B
        issue(5'b00100, 8'h20, 8'h50);  // R3 A<B borrow
        issue(5'b00100, 8'h77, 8'h77);  // R3 equal, zero
        issue(5'b00101, 8'hA5, 8'hFF);  // R6 xor
        issue(5'b00111, 8'hF0, 8'h3C);  // R6 and
        issue(5'b01000, 8'h0F, 8'h30);  // R6 or
        issue(5'b00111, 8'h0F, 8'hF0);  // R6 and to zero
        idle(2);
        issue(5'b10010, 8'hFF, 8'h55);  // R5 inc wrap, B ignored
        issue(5'b10010, 8'h7F, 8'hAA);  // R5 inc
        issue(5'b10011, 8'h00, 8'h12);  // R5 dec wrap
        issue(5'b10011, 8'h01, 8'hFF);  // R5 dec to zero
        issue(5'b11010, 8'h00, 8'h00);  // R7 flood, flags held
        issue(5'b00000, 8'hFF, 8'hFF);  // R8 unused opcode
        issue(5'b11100, 8'h12, 8'h34);  // R8 unused opcode
        idle(4);
        // R4: add-with-carry after both carry states (pipe drained)
        issue(5'b00011, 8'hF0, 8'h20);  // sets carry
        idle(4);
        issue(5'b10001, 8'h10, 8'h20);  // R4 with carry=1 -> 31
        idle(4);
        issue(5'b10001, 8'h10, 8'h20);  // R4 with carry=0 -> 30
        idle(4);
        issue(5'b10001, 8'hFF, 8'h01);  // R4 wrap, carry=0 -> 00
        idle(4);
        issue(5'b10001, 8'hFF, 8'h00);  // R4 carry=1 -> 00 carry 1
        idle(1);
        issue(5'b11010, 8'h01, 8'h01);  // R7 flood after carry set
        idle(6);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1 missing results: actual %0d pending expected 0", sb.size());
        end
        done = 1'b1;
    end

    initial begin
        wait (done || cyc >= MAX_CYCLES);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual %0d cycles expected completion", cyc);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule